// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Entry

This block is the control unit of a multicycle 32-bit processor whose datapath has one ALU and one memory, both used by several stages. A state register steps each instruction through only the stages it needs. The stages are fetch, decode with register read, ALU execute or address generation, memory access, and register write-back. Each stage lasts one clock cycle. In every state the block drives a set of control strobes and multiplexer selects for the datapath around it.

Two faults take the sequencer into an exception state: an opcode it does not recognise, and an arithmetic overflow raised while a register-format operation executes. In that state the block saves the faulting instruction's address in an exception-PC register. It also writes a cause register, steers the next PC to one fixed handler address, and then returns to fetch. The datapath supplies the already-incremented PC on `pc_in`, so the saved address is that value minus 4. The opcode comes from the datapath's instruction register, and the overflow flag comes from the ALU.

Top module: `mcc_ctrl`

## Requirements
- R1: While reset is low (asynchronous, active low), the state is fetch (code 0), `mem_write`, `reg_write` and `epc_write` are 0, and the exception-PC and cause registers read 0. A reset in the middle of an instruction returns the state to fetch at once.
- R2: State codes are: fetch 0, decode 1, address 2, load-memory 3, load-writeback 4, store-memory 5, reg-execute 6, reg-writeback 7, branch 8, undefined-op exception 9, overflow exception 10. In fetch the block asserts `mem_read`, `ir_write` and `pc_write`, with `iord`=0, `pc_src`=00 (ALU result) and `alu_src_b`=01 (constant 4).
- R3: Decode always follows fetch. The state after decode is 2 for opcodes 6'h23 and 6'h2B, 6 for 6'h00, 8 for 6'h04 and 9 for any other opcode.
- R4: A load (6'h23) takes 5 cycles. It reads memory twice: once in fetch, and once in load-memory with `iord`=1. It writes one register with `mem_to_reg`=1 and `reg_dst`=0.
- R5: A store (6'h2B) takes 4 cycles. It asserts `mem_write` exactly once, with `iord`=1, and writes no register.
- R6: A register-format operation (6'h00) without overflow takes 4 cycles. It asserts `alu_op`=10 in execute and writes one register with `reg_dst`=1 and `mem_to_reg`=0.
- R7: A branch (6'h04) takes 3 cycles. It asserts `pc_write_cond` once, with `pc_src`=01 (branch target) and `alu_op`=01 (subtract).
- R8: If `overflow` is high in reg-execute, the next state is the overflow exception. That instruction then writes no register, and the whole sequence takes 4 cycles.
- R9: `overflow` has no effect in any state other than reg-execute.
- R10: Each exception state lasts one cycle, then the state goes to fetch. In that cycle the block asserts `epc_write`, `cause_write` and `pc_write` with `pc_src`=11 (handler). `int_cause` is 0 for an undefined opcode and 1 for overflow.
- R11: At the clock edge that ends an exception state, the exception-PC register loads `pc_in`−4 and the cause register loads `int_cause` in bit 0 with zeros above it. At all other times both registers hold their value.
- R12: `handler_pc` equals the parameter HANDLER_ADDR, which defaults to 32'h8000_0180.
- R13: `mem_read` and `mem_write` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field from the instruction register |
| overflow | input | 1 | ALU overflow flag |
| pc_in | input | XLEN | Current PC value, already incremented by fetch |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load when the ALU zero flag is set |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 ALU output, 1 memory data |
| reg_dst | output | 1 | Destination field: 0 rt, 1 rd |
| reg_write | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 decode function field |
| pc_src | output | 2 | Next PC: 00 ALU result, 01 branch target, 11 handler |
| epc_write | output | 1 | Exception-PC load strobe |
| cause_write | output | 1 | Cause register load strobe |
| int_cause | output | 1 | Cause code: 0 undefined opcode, 1 overflow |
| state_code | output | 4 | Current state code |
| epc_out | output | XLEN | Exception-PC register |
| cause_out | output | XLEN | Cause register |
| handler_pc | output | XLEN | Fixed exception handler address |

## Verification
The assertions assume that `opcode` stays stable from fetch until the sequence returns to fetch, as it would when it comes from the instruction register. They also assume that `pc_in` holds the incremented PC while an exception state is active, so that "loaded value equals previous `pc_in` minus 4" is meaningful. `overflow` may change freely, and the assertions examine it only in reg-execute. The stimulus changes `opcode`, `overflow` and `pc_in` only on the falling edge at which a new fetch begins, and it holds them there for the whole instruction. It sweeps all 64 opcodes with `overflow` held low and again with it held high.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OP_W = 6;

  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LDMEM   = 4'd3,
    ST_LDWB    = 4'd4,
    ST_STMEM   = 4'd5,
    ST_REXEC   = 4'd6,
    ST_RWB     = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_EXC_UND = 4'd9,
    ST_EXC_OVF = 4'd10
  } mcc_state_e;

  typedef enum logic [2:0] {
    CL_RTYPE, CL_LOAD, CL_STORE, CL_BRANCH, CL_UNDEF
  } mcc_class_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

  typedef struct packed {
    logic       pc_write;
    logic       pc_write_cond;
    logic       iord;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       reg_write;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       epc_write;
    logic       cause_write;
    logic       int_cause;
  } mcc_ctrl_t;

  function automatic mcc_class_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OPC_RTYPE: return CL_RTYPE;
      OPC_LOAD:  return CL_LOAD;
      OPC_STORE: return CL_STORE;
      OPC_BEQ:   return CL_BRANCH;
      default:   return CL_UNDEF;
    endcase
  endfunction

endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OP_W-1:0]      opcode,
  input  logic                 overflow,
  output mcc_state_e           state,
  output logic                 ovf_taken
);

  mcc_state_e nxt;
  mcc_class_e cls;

  assign cls       = op_class(opcode);
  assign ovf_taken = (state == ST_REXEC) && overflow;

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_RTYPE:          nxt = ST_REXEC;
          CL_BRANCH:         nxt = ST_BRANCH;
          default:           nxt = ST_EXC_UND;
        endcase
      end
      ST_ADDR:   nxt = (cls == CL_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_REXEC:  nxt = ovf_taken ? ST_EXC_OVF : ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

endmodule

// File: rtl/mcc_strobes.sv
module mcc_strobes
  import mcc_pkg::*;
(
  input  mcc_state_e state,
  output mcc_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (state)
      ST_FETCH: begin
        ctrl.mem_read  = 1'b1;
        ctrl.ir_write  = 1'b1;
        ctrl.alu_src_b = 2'b01;
        ctrl.pc_write  = 1'b1;
      end
      ST_DECODE:  ctrl.alu_src_b = 2'b11;
      ST_ADDR: begin
        ctrl.alu_src_a = 1'b1;
        ctrl.alu_src_b = 2'b10;
      end
      ST_LDMEM: begin
        ctrl.mem_read = 1'b1;
        ctrl.iord     = 1'b1;
      end
      ST_LDWB: begin
        ctrl.reg_write  = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      ST_STMEM: begin
        ctrl.mem_write = 1'b1;
        ctrl.iord      = 1'b1;
      end
      ST_REXEC: begin
        ctrl.alu_src_a = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      ST_RWB: begin
        ctrl.reg_write = 1'b1;
        ctrl.reg_dst   = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_src_a     = 1'b1;
        ctrl.alu_op        = 2'b01;
        ctrl.pc_write_cond = 1'b1;
        ctrl.pc_src        = 2'b01;
      end
      ST_EXC_UND, ST_EXC_OVF: begin
        ctrl.epc_write   = 1'b1;
        ctrl.cause_write = 1'b1;
        ctrl.pc_write    = 1'b1;
        ctrl.pc_src      = 2'b11;
        ctrl.int_cause   = (state == ST_EXC_OVF);
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mcc_exc_regs.sv
module mcc_exc_regs #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            epc_write,
  input  logic            cause_write,
  input  logic            int_cause,
  input  logic [XLEN-1:0] pc_in,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);

  function automatic logic [XLEN-1:0] restart_addr(input logic [XLEN-1:0] pc);
    return pc - XLEN'(PC_STEP);
  endfunction

  function automatic logic [XLEN-1:0] cause_word(input logic code);
    return {{(XLEN-1){1'b0}}, code};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else begin
      if (epc_write)   epc   <= restart_addr(pc_in);
      if (cause_write) cause <= cause_word(int_cause);
    end
  end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              PC_STEP      = 4,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      opcode,
  input  logic            overflow,
  input  logic [XLEN-1:0] pc_in,
  output logic            pc_write,
  output logic            pc_write_cond,
  output logic            iord,
  output logic            mem_read,
  output logic            mem_write,
  output logic            ir_write,
  output logic            mem_to_reg,
  output logic            reg_dst,
  output logic            reg_write,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      alu_op,
  output logic [1:0]      pc_src,
  output logic            epc_write,
  output logic            cause_write,
  output logic            int_cause,
  output logic [3:0]      state_code,
  output logic [XLEN-1:0] epc_out,
  output logic [XLEN-1:0] cause_out,
  output logic [XLEN-1:0] handler_pc
);

  mcc_state_e state;
  mcc_ctrl_t  ctrl;
  logic       ovf_taken;

  mcc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .overflow  (overflow),
    .state     (state),
    .ovf_taken (ovf_taken)
  );

  mcc_strobes u_strobes (
    .state (state),
    .ctrl  (ctrl)
  );

  mcc_exc_regs #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_exc (
    .clk         (clk),
    .rst_n       (rst_n),
    .epc_write   (ctrl.epc_write),
    .cause_write (ctrl.cause_write),
    .int_cause   (ctrl.int_cause),
    .pc_in       (pc_in),
    .epc         (epc_out),
    .cause       (cause_out)
  );

  assign pc_write      = ctrl.pc_write;
  assign pc_write_cond = ctrl.pc_write_cond;
  assign iord          = ctrl.iord;
  assign mem_read      = ctrl.mem_read;
  assign mem_write     = ctrl.mem_write;
  assign ir_write      = ctrl.ir_write;
  assign mem_to_reg    = ctrl.mem_to_reg;
  assign reg_dst       = ctrl.reg_dst;
  assign reg_write     = ctrl.reg_write;
  assign alu_src_a     = ctrl.alu_src_a;
  assign alu_src_b     = ctrl.alu_src_b;
  assign alu_op        = ctrl.alu_op;
  assign pc_src        = ctrl.pc_src;
  assign epc_write     = ctrl.epc_write;
  assign cause_write   = ctrl.cause_write;
  assign int_cause     = ctrl.int_cause;
  assign state_code    = state;
  assign handler_pc    = HANDLER_ADDR;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            overflow,
  input logic            ovf_taken,
  input logic [3:0]      state_code,
  input logic            reg_write,
  input logic            mem_read,
  input logic            mem_write,
  input logic            epc_write,
  input logic            cause_write,
  input logic [XLEN-1:0] pc_in,
  input logic [XLEN-1:0] epc_out,
  input logic [XLEN-1:0] cause_out
);

  // R3: decode always follows fetch
  p_fetch_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0) |=> (state_code == 4'd1));

  // R8: overflow seen in reg-execute leads to the overflow exception state
  p_ovf_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd6 && overflow) |=> (state_code == 4'd10));

  // R8: no register write in the cycle after an overflow was taken
  p_ovf_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_taken |=> !reg_write);

  // R9: the overflow exception is only ever reached from reg-execute
  p_ovf_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 4'd6) |=> (state_code != 4'd10));

  // R10: an exception state lasts one cycle and returns to fetch
  p_exc_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    epc_write |=> (state_code == 4'd0));

  // R11: exception-PC takes the previous pc_in minus 4
  p_epc_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    epc_write |=> (epc_out == $past(pc_in) - XLEN'(4)));

  // R11: both exception registers hold when not written
  p_epc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!epc_write && !cause_write) |=> ($stable(epc_out) && $stable(cause_out)));

  // R13: memory is never read and written in the same cycle
  p_mem_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

endmodule

bind mcc_ctrl mcc_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .overflow    (overflow),
  .ovf_taken   (ovf_taken),
  .state_code  (state_code),
  .reg_write   (reg_write),
  .mem_read    (mem_read),
  .mem_write   (mem_write),
  .epc_write   (epc_write),
  .cause_write (cause_write),
  .pc_in       (pc_in),
  .epc_out     (epc_out),
  .cause_out   (cause_out)
);

// File: tb/sim_mcc_ctrl.sv
`timescale 1ns/1ps
module sim_mcc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = 6'h00;
  logic        overflow = 1'b0;
  logic [31:0] pc_in = 32'h0;
  logic        pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
  logic        mem_to_reg, reg_dst, reg_write, alu_src_a;
  logic [1:0]  alu_src_b, alu_op, pc_src;
  logic        epc_write, cause_write, int_cause;
  logic [3:0]  state_code;
  logic [31:0] epc_out, cause_out, handler_pc;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_epc   = 32'h0;
  logic [31:0] exp_cause = 32'h0;

  always #4 clk = ~clk;

  mcc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .overflow(overflow), .pc_in(pc_in),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond), .iord(iord),
    .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
    .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_write(reg_write),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_src(pc_src),
    .epc_write(epc_write), .cause_write(cause_write), .int_cause(int_cause),
    .state_code(state_code), .epc_out(epc_out), .cause_out(cause_out),
    .handler_pc(handler_pc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one instruction starting at a falling edge in fetch; ends at the next fetch.
  task automatic run_instr(input logic [5:0] op, input logic ovf, input logic [31:0] base);
    bit is_r, is_lw, is_sw, is_beq, is_und, ovf_exc, any_exc;
    int len = 0, n_mr = 0, n_mw = 0, n_rw = 0, n_io = 0, n_pwc = 0, n_epc = 0;
    logic [3:0] disp = 4'hF, exp_disp;
    int exp_len;
    logic rw_m2r = 1'b0, rw_dst = 1'b0, ic = 1'b0, pw_exc = 1'b0, cw_exc = 1'b0;
    logic [1:0] ps_exc = 2'b00, ps_br = 2'b00, op_br = 2'b00;
    string lreq;
    is_r   = (op == 6'h00);
    is_lw  = (op == 6'h23);
    is_sw  = (op == 6'h2B);
    is_beq = (op == 6'h04);
    is_und = !(is_r || is_lw || is_sw || is_beq);
    ovf_exc = is_r && ovf;
    any_exc = is_und || ovf_exc;
    opcode   = op;
    overflow = ovf;
    pc_in    = base + 32'd4;
    while (len < 12) begin
      if (len > 0 && state_code == 4'd0) break;
      if (len == 0)
        check(mem_read && ir_write && pc_write && !iord && pc_src == 2'b00 &&
              alu_src_b == 2'b01, "R2 fetch strobes", {26'b0, mem_read, ir_write,
              pc_write, iord, alu_src_b}, 32'h39);
      if (len == 2) disp = state_code;
      if (mem_read) n_mr++;
      if (mem_write) n_mw++;
      if (iord && (mem_read || mem_write)) n_io++;
      if (reg_write) begin n_rw++; rw_m2r = mem_to_reg; rw_dst = reg_dst; end
      if (pc_write_cond) begin n_pwc++; ps_br = pc_src; op_br = alu_op; end
      if (epc_write) begin
        n_epc++; ic = int_cause; ps_exc = pc_src; pw_exc = pc_write; cw_exc = cause_write;
      end
      len++;
      @(negedge clk);
    end
    exp_disp = (is_lw || is_sw) ? 4'd2 : is_r ? 4'd6 : is_beq ? 4'd8 : 4'd9;
    check(disp == exp_disp, "R3 dispatch state", 32'(disp), 32'(exp_disp));
    exp_len = is_lw ? 5 : (is_sw || is_r) ? 4 : 3;
    lreq = is_lw ? "R4 length" : is_sw ? "R5 length" : ovf_exc ? "R8 length" :
           is_r ? "R6 length" : is_beq ? "R7 length" : "R10 length";
    if (ovf && !is_r) lreq = "R9 length";
    check(len == exp_len, lreq, 32'(len), 32'(exp_len));
    check(n_mr == (is_lw ? 2 : 1), "R4 memory reads", 32'(n_mr), is_lw ? 2 : 1);
    check(n_mw == (is_sw ? 1 : 0), "R5 memory writes", 32'(n_mw), is_sw ? 1 : 0);
    check(n_io == ((is_lw || is_sw) ? 1 : 0), "R4 data access via iord", 32'(n_io),
          (is_lw || is_sw) ? 1 : 0);
    check(n_rw == ((is_lw || (is_r && !ovf)) ? 1 : 0), ovf_exc ? "R8 no writeback" :
          "R6 register writes", 32'(n_rw), (is_lw || (is_r && !ovf)) ? 1 : 0);
    if (is_lw)
      check(rw_m2r && !rw_dst, "R4 load writeback select", {30'b0, rw_m2r, rw_dst}, 32'h2);
    if (is_r && !ovf)
      check(!rw_m2r && rw_dst, "R6 reg writeback select", {30'b0, rw_m2r, rw_dst}, 32'h1);
    check(n_pwc == (is_beq ? 1 : 0), "R7 conditional pc write", 32'(n_pwc), is_beq ? 1 : 0);
    if (is_beq)
      check(ps_br == 2'b01 && op_br == 2'b01, "R7 branch selects", {28'b0, ps_br, op_br},
            32'h5);
    check(n_epc == (any_exc ? 1 : 0), (ovf && !is_r) ? "R9 no exception" :
          "R10 exception count", 32'(n_epc), any_exc ? 1 : 0);
    if (any_exc) begin
      check(ic == ovf_exc, "R10 int_cause", 32'(ic), 32'(ovf_exc));
      check(ps_exc == 2'b11 && pw_exc && cw_exc, "R10 exception strobes",
            {28'b0, ps_exc, pw_exc, cw_exc}, 32'hF);
      exp_epc   = base;
      exp_cause = {31'b0, ovf_exc};
    end
    check(epc_out == exp_epc, "R11 epc value", epc_out, exp_epc);
    check(cause_out == exp_cause, "R11 cause value", cause_out, exp_cause);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(state_code == 4'd0 && !mem_write && !reg_write && !epc_write, "R1 reset state",
          32'(state_code), 32'h0);
    check(epc_out == 32'h0 && cause_out == 32'h0, "R1 reset exception regs",
          epc_out | cause_out, 32'h0);
    // R12: handler address
    check(handler_pc == 32'h8000_0180, "R12 handler address", handler_pc, 32'h8000_0180);
    rst_n = 1'b1;
    for (int op = 0; op < 64; op++)
      run_instr(6'(op), 1'b0, 32'h0040_0000 + 32'(op) * 32'd8);
    for (int op = 0; op < 64; op++)
      run_instr(6'(op), 1'b1, 32'h1000_0000 + 32'(op) * 32'd16);
    run_instr(6'h00, 1'b0, 32'h2000_0100);
    run_instr(6'h3F, 1'b1, 32'h3000_0040);
    // R1: reset in the middle of a load returns to fetch
    opcode = 6'h23;
    overflow = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(state_code == 4'd2, "R1 mid-load state before reset", 32'(state_code), 32'h2);
    rst_n = 1'b0;
    #1;
    check(state_code == 4'd0, "R1 reset mid-instruction", 32'(state_code), 32'h0);
    check(epc_out == 32'h0, "R1 reset clears epc", epc_out, 32'h0);
    exp_epc = 32'h0;
    exp_cause = 32'h0;
    @(negedge clk);
    rst_n = 1'b1;
    run_instr(6'h23, 1'b0, 32'h0000_1000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule